// File: doc/BRIEF.md
# Edge-Placed PWM Channel

A single pulse-width output generator. A prescaler divides the system clock into ticks. A position counter steps once per tick through one base period. The output is active while the position lies between a programmed rise point and a programmed fall point. The timing values come in on plain configuration ports and are captured when the channel starts.

The channel runs in one of two ways. With a cycle count of zero it runs forever. With any other count it emits exactly that many periods, then stops by itself and raises a done flag. A reload pulse stages new rise, fall and period values while the channel runs. The staged values take over at the next period boundary, so no period is ever cut short or mixed. A stop pulse halts the channel at once. An inversion flag flips the output polarity, including the idle level. A counter output reports how many periods have completed since the last start.

Top module: `edge_pwm`

## Requirements
- R1: After reset, `pwm_out` is 0, `busy` is 0, `done` is 0 and `periods_done` is 0.
- R2: One tick lasts D = max(divider, 3) + 1 clocks. A period lasts P = prd × D clocks, where a period value below 2 counts as 2.
- R3: Counting t as the number of clocks since the start edge, the position is (t / D) mod prd. The raw output is 1 exactly when rise ≤ position < fall, which makes the duty (fall − rise) / prd.
- R4: A fall value above the period is limited to the period, and a rise value above the limited fall is limited to that fall.
- R5: With a cycle count N > 0, `busy` falls and `done` rises N × P clocks after the start edge. From then on `pwm_out` sits at its inactive level.
- R6: With a cycle count of 0 the channel keeps running until it is stopped.
- R7: An inversion flag of 1, captured at start, inverts `pwm_out` both while running and while idle.
- R8: A reload pulse during a run stages new period, rise and fall values, and these apply from the next period boundary onward. A reload pulse while idle has no effect on a later run.
- R9: A stop pulse makes the channel idle on the next clock edge: `busy` goes to 0, `done` goes to 1, `pwm_out` goes to its inactive level, and `periods_done` holds its value.
- R10: `periods_done` rises by one at each completed period and is cleared by a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 14 | Prescaler divider; values below 3 are treated as 3 |
| cfg_prd | input | 8 | Base period in ticks |
| cfg_rise | input | 8 | Position at which the output becomes active |
| cfg_fall | input | 8 | Position at which the output becomes inactive |
| cfg_cycles | input | 16 | Number of periods to emit; 0 means run forever |
| cfg_inv | input | 1 | Output inversion flag |
| start | input | 1 | Pulse: capture the configuration and begin a run |
| stop | input | 1 | Pulse: halt at once; takes priority over start |
| reload | input | 1 | Pulse: stage new period, rise and fall for the next boundary |
| pwm_out | output | 1 | Waveform output |
| busy | output | 1 | Channel is running |
| done | output | 1 | A run has ended by burst completion or stop; cleared by start |
| periods_done | output | 16 | Periods completed since the last start |

## Verification
The properties assume that start, stop and reload arrive as synchronous pulses. They also assume that a reload never comes in the same cycle as a start. Every bench pulse lasts exactly one clock, is driven on the falling edge, and reloads are issued only mid-period during a run. Configurations are drawn at random over ranges that include values below the divider floor and the period floor and rise and fall values beyond the period, so the clamping is exercised. Directed cases then cover reload timing, idle reload, inversion and stop.

// File: rtl/edge_pwm.sv
module edge_pwm #(
  parameter int DIV_W   = 14,
  parameter int PRD_W   = 8,
  parameter int CNT_W   = 16,
  parameter int MIN_DIV = 3,
  parameter int MIN_PRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [PRD_W-1:0] cfg_prd,
  input  logic [PRD_W-1:0] cfg_rise,
  input  logic [PRD_W-1:0] cfg_fall,
  input  logic [CNT_W-1:0] cfg_cycles,
  input  logic             cfg_inv,
  input  logic             start,
  input  logic             stop,
  input  logic             reload,
  output logic             pwm_out,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] periods_done
);
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);
  localparam logic [PRD_W-1:0] PRD_FLOOR = PRD_W'(MIN_PRD);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [DIV_W-1:0] div_c, div_q, pre_q;
  logic [PRD_W-1:0] prd_c, rise_c, fall_c;
  logic [PRD_W-1:0] prd_q, rise_q, fall_q, pos_q;
  logic [PRD_W-1:0] prd_s, rise_s, fall_s;
  logic [CNT_W-1:0] cyc_q, cnt_q;
  logic             inv_q, pend_q;
  logic             tick, wrap, last;

  assign div_c  = (cfg_div < DIV_FLOOR) ? DIV_FLOOR : cfg_div;
  assign prd_c  = (cfg_prd < PRD_FLOOR) ? PRD_FLOOR : cfg_prd;
  assign fall_c = (cfg_fall > prd_c) ? prd_c : cfg_fall;
  assign rise_c = (cfg_rise > fall_c) ? fall_c : cfg_rise;

  assign tick = busy && (pre_q == div_q);
  assign wrap = tick && (pos_q == prd_q - PRD_W'(1));
  assign last = wrap && (cyc_q != '0) && (cnt_q + CNT_W'(1) == cyc_q);

  assign pwm_out      = inv_q ^ (busy && (pos_q >= rise_q) && (pos_q < fall_q));
  assign periods_done = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      pre_q  <= '0;
      pos_q  <= '0;
      cnt_q  <= '0;
      div_q  <= DIV_FLOOR;
      prd_q  <= PRD_FLOOR;
      rise_q <= '0;
      fall_q <= '0;
      prd_s  <= PRD_FLOOR;
      rise_s <= '0;
      fall_s <= '0;
      cyc_q  <= '0;
      inv_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (stop) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else if (start) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      pre_q  <= '0;
      pos_q  <= '0;
      cnt_q  <= '0;
      div_q  <= div_c;
      prd_q  <= prd_c;
      rise_q <= rise_c;
      fall_q <= fall_c;
      cyc_q  <= cfg_cycles;
      inv_q  <= cfg_inv;
      pend_q <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        pre_q <= '0;
        if (wrap) begin
          pos_q <= '0;
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else if (pend_q) begin
            prd_q  <= prd_s;
            rise_q <= rise_s;
            fall_q <= fall_s;
            pend_q <= 1'b0;
          end
        end else begin
          pos_q <= pos_q + PRD_W'(1);
        end
      end else begin
        pre_q <= pre_q + DIV_W'(1);
      end
      if (reload) begin
        prd_s  <= prd_c;
        rise_s <= rise_c;
        fall_s <= fall_c;
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_pwm_chk.sv
module edge_pwm_chk #(
  parameter int PRD_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic             pwm_out,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] periods_done,
  input logic [PRD_W-1:0] prd_q,
  input logic [PRD_W-1:0] rise_q,
  input logic [PRD_W-1:0] fall_q,
  input logic [PRD_W-1:0] pos_q,
  input logic [CNT_W-1:0] cyc_q,
  input logic             inv_q
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> pwm_out == inv_q); // R7
  AST_EDGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rise_q <= fall_q) && (fall_q <= prd_q)); // R4
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pos_q < prd_q); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_q != '0) |-> periods_done < cyc_q); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(start)) |->
      (periods_done == $past(periods_done) || periods_done == $past(periods_done) + CNT_W'(1))); // R10
  AST_MID_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(start) && pos_q != '0) |->
      ($stable(prd_q) && $stable(rise_q) && $stable(fall_q))); // R8
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && done)); // R9
endmodule

bind edge_pwm edge_pwm_chk #(.PRD_W(PRD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .pwm_out(pwm_out), .busy(busy), .done(done), .periods_done(periods_done),
  .prd_q(prd_q), .rise_q(rise_q), .fall_q(fall_q), .pos_q(pos_q),
  .cyc_q(cyc_q), .inv_q(inv_q)
);

// File: tb/edge_pwm_bench.sv
module edge_pwm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] cfg_div = '0;
  logic [7:0]  cfg_prd = '0, cfg_rise = '0, cfg_fall = '0;
  logic [15:0] cfg_cycles = '0;
  logic        cfg_inv = 1'b0;
  logic        start = 1'b0, stop = 1'b0, reload = 1'b0;
  logic        pwm_out, busy, done;
  logic [15:0] periods_done;
  int          n_tests = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  edge_pwm u_edge_pwm (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_prd(cfg_prd),
    .cfg_rise(cfg_rise), .cfg_fall(cfg_fall), .cfg_cycles(cfg_cycles),
    .cfg_inv(cfg_inv), .start(start), .stop(stop), .reload(reload),
    .pwm_out(pwm_out), .busy(busy), .done(done), .periods_done(periods_done)
  );

  function automatic int eff_d(int d);
    return ((d < 3) ? 3 : d) + 1;
  endfunction
  function automatic int eff_p(int p);
    return (p < 2) ? 2 : p;
  endfunction
  function automatic int eff_f(int f, int p);
    return (f > eff_p(p)) ? eff_p(p) : f;
  endfunction
  function automatic int eff_r(int r, int f, int p);
    return (r > eff_f(f, p)) ? eff_f(f, p) : r;
  endfunction
  function automatic bit wave(int t, int d, int p, int r, int f, bit inv);
    int pp, ff, rr, pos;
    pp = eff_p(p); ff = eff_f(f, p); rr = eff_r(r, f, p);
    pos = (t / eff_d(d)) % pp;
    return inv ^ ((pos >= rr) && (pos < ff));
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(int d, int p, int r, int f, int n, bit inv);
    cfg_div = 14'(d); cfg_prd = 8'(p); cfg_rise = 8'(r); cfg_fall = 8'(f);
    cfg_cycles = 16'(n); cfg_inv = inv;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Finite burst: R2 R3 R4 R5 R7 R10
  task automatic run_burst(int d, int p, int r, int f, int n, bit inv);
    int total, bad, first_t, first_a, first_e, cbad;
    set_cfg(d, p, r, f, n, inv);
    pulse_start();
    total = n * eff_p(p) * eff_d(d);
    bad = 0; cbad = 0; first_t = -1; first_a = 0; first_e = 0;
    for (int t = 0; t < total; t++) begin
      if (t > 0) @(negedge clk);
      if (pwm_out !== wave(t, d, p, r, f, inv) || busy !== 1'b1) begin
        if (bad == 0) begin
          first_t = t; first_a = {busy, pwm_out}; first_e = {1'b1, wave(t, d, p, r, f, inv)};
        end
        bad++;
      end
      if (periods_done != 16'(t / (eff_p(p) * eff_d(d)))) cbad++;
    end
    check("R3", $sformatf("waveform mismatches (first t=%0d act=%0d exp=%0d)", first_t, first_a, first_e), bad, 0);
    check("R10", "running period count mismatches", cbad, 0);
    @(negedge clk);
    check("R5", "busy after burst", busy, 0);
    check("R5", "done after burst", done, 1);
    check("R7", "idle level after burst", pwm_out, inv);
    check("R10", "periods after burst", periods_done, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "pwm_out in reset", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pwm_out after reset", pwm_out, 0);
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);
    check("R1", "periods_done after reset", periods_done, 0);

    // Directed: divider floor, period floor, fall/rise clamps (R2, R4)
    run_burst(0, 1, 0, 1, 2, 1'b0);
    run_burst(5, 4, 3, 9, 2, 1'b0);
    run_burst(3, 5, 7, 2, 1, 1'b1);
    run_burst(4, 6, 0, 6, 1, 1'b0);

    // Random bursts
    for (int i = 0; i < 8; i++)
      run_burst(int'($urandom_range(0, 6)), int'($urandom_range(0, 10)),
                int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
                int'($urandom_range(1, 3)), 1'($urandom_range(0, 1)));

    // Free run, then stop (R6, R9)
    set_cfg(3, 5, 1, 3, 0, 1'b1);
    pulse_start();
    bad = 0;
    for (int t = 0; t < 3 * 20; t++) begin
      if (t > 0) @(negedge clk);
      if (pwm_out !== wave(t, 3, 5, 1, 3, 1'b1) || busy !== 1'b1) bad++;
    end
    @(negedge clk);
    check("R6", "free-run mismatches", bad, 0);
    check("R6", "still busy after 3 periods", busy, 1);
    check("R10", "periods in free run", periods_done, 3);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check("R9", "busy after stop", busy, 0);
    check("R9", "done after stop", done, 1);
    check("R9", "idle level after stop", pwm_out, 1);
    check("R9", "periods held after stop", periods_done, 3);

    // Reload mid-period (R8): old period 4x4=16 clocks, new from t=16
    set_cfg(3, 4, 0, 2, 0, 1'b0);
    pulse_start();
    check("R10", "periods cleared by start", periods_done, 0);
    bad = 0;
    for (int t = 0; t < 16 + 48; t++) begin
      if (t > 0) @(negedge clk);
      if (t == 5) begin set_cfg(3, 6, 1, 4, 0, 1'b0); reload = 1'b1; end
      if (t == 6) reload = 1'b0;
      if (t < 16) begin
        if (pwm_out !== wave(t, 3, 4, 0, 2, 1'b0)) bad++;
      end else begin
        if (pwm_out !== wave(t - 16, 3, 6, 1, 4, 1'b0)) bad++;
      end
    end
    check("R8", "reload boundary mismatches", bad, 0);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check("R9", "stop after reload run", busy, 0);

    // Idle reload has no effect on a later run (R8)
    set_cfg(3, 8, 0, 8, 0, 1'b0);
    @(negedge clk); reload = 1'b1;
    @(negedge clk); reload = 1'b0;
    set_cfg(3, 4, 2, 3, 3, 1'b0);
    pulse_start();
    bad = 0;
    for (int t = 0; t < 48; t++) begin
      if (t > 0) @(negedge clk);
      if (pwm_out !== wave(t, 3, 4, 2, 3, 1'b0)) bad++;
    end
    check("R8", "idle reload leaked into run", bad, 0);
    @(negedge clk);
    check("R5", "burst of 3 ended", busy, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule